// File: doc/BRIEF.md
# Packed Grayscale Channel Serializer

This block keeps a 12-bit grayscale level for every output channel of a chain of constant-current driver chips. Each chip has sixteen channels, and the number of chips is a parameter. When the sequencer asks for a frame, the block shifts the whole set of levels out as one continuous serial stream on a data and clock pair. The sequencer then pulses the chips' latch itself. A host write port changes one channel at a time, and a dirty flag tells the sequencer whether any level has changed since the last frame began.

Straight after reset the block flushes the chain. It shifts more zero bits than one frame holds, so that stale data from power-up falls off the far end of the chain. It then raises a one-cycle latch request so that every output register starts at zero. Frame requests are accepted only after that.

Top module: `gs_frame_serializer`

## Requirements
- R1: A frame carries exactly 192·NUM_CHIPS bits, one rising edge of `sclk` per bit.
- R2: Channels leave highest index first (channel 16·NUM_CHIPS−1 down to channel 0). Each level is sent most significant bit first, with no gap or padding between channels.
- R3: `sclk` is low whenever `busy` is low. `sdata` changes only while `sclk` is low, so it is stable at each rising edge and for as long as `sclk` stays high (clock polarity 0, phase 0).
- R4: A write whose `wr_idx` is 16·NUM_CHIPS or more changes no channel and leaves `dirty` unchanged.
- R5: A write with an index in range replaces only that channel's 12 bits and sets `dirty` in the following cycle.
- R6: After reset the block shifts 200·NUM_CHIPS zero bits, then pulses `latch_req` for one cycle, then raises `ready`. `frame_req` is ignored until `ready` is high.
- R7: After reset every channel holds zero.
- R8: A write made while a frame is shifting does not alter that frame. It appears in the next frame.
- R9: `done` is high for exactly one cycle, in the cycle after the last bit period ends. `dirty` clears when a frame starts, unless a valid write lands in that same cycle.
- R10: One bit period lasts CLK_DIV system clocks. In each period `sclk` is low for CLK_DIV/2 clocks and then high for the remaining clocks.
- R11: A `frame_req` that arrives while `busy` is high is ignored. It neither restarts nor extends the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_idx | input | $clog2(16·NUM_CHIPS)+1 | Channel index of the write |
| wr_data | input | 12 | Grayscale level to write |
| frame_req | input | 1 | Sequencer request to shift one frame |
| sclk | output | 1 | Serial clock, idles low |
| sdata | output | 1 | Serial data |
| busy | output | 1 | Clearing, latch request or frame in progress |
| ready | output | 1 | Power-on clear has finished |
| latch_req | output | 1 | One-cycle request for the latch after the clear |
| done | output | 1 | One-cycle pulse when a frame has finished |
| dirty | output | 1 | A level has changed since the last frame began |

## Verification
The assertions assume that `frame_req` and `wr_en` are synchronous to `clk` and valid for whole cycles. They also assume that `wr_data` matters only while `wr_en` is high, and that `wr_idx` may take any value, including indices beyond the last channel. The bench drives every input on the falling edge, so each write or request is held for exactly one rising edge. It also issues requests during the power-on clear and in the middle of a frame, so that the rules on ignored requests are exercised rather than assumed.

// File: rtl/gsser_pkg.sv
package gsser_pkg;
  localparam int GS_BITS       = 12;
  localparam int CH_PER_CHIP   = 16;
  localparam int FLUSH_BYTES   = 25;

  function automatic int chan_count(input int chips);
    return chips * CH_PER_CHIP;
  endfunction

  function automatic int frame_bits(input int chips);
    return chips * CH_PER_CHIP * GS_BITS;
  endfunction

  function automatic int flush_bits(input int chips);
    return chips * FLUSH_BYTES * 8;
  endfunction

  typedef enum logic [1:0] {
    ST_FLUSH = 2'd0,
    ST_LATCH = 2'd1,
    ST_IDLE  = 2'd2,
    ST_SEND  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/gsser_store.sv
module gsser_store #(
  parameter int NCH   = 16,
  parameter int IDX_W = 5,
  parameter int GS_W  = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [GS_W-1:0]       wr_data,
  output logic                  wr_ok,
  output logic [NCH*GS_W-1:0]   levels
);
  localparam logic [IDX_W-1:0] NCH_L = IDX_W'(NCH);

  assign wr_ok = wr_en && (wr_idx < NCH_L);

  // one register per channel; channel g occupies bits [g*GS_W +: GS_W]
  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic [GS_W-1:0] lvl_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lvl_q <= '0;
      else if (wr_ok && (wr_idx == IDX_W'(g)))
        lvl_q <= wr_data;
    end
    assign levels[g*GS_W +: GS_W] = lvl_q;
  end
endmodule

// File: rtl/gsser_shifter.sv
module gsser_shifter #(
  parameter int SR_W       = 192,
  parameter int CNT_W      = 9,
  parameter int CLK_DIV    = 2,
  parameter int RESET_BITS = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SR_W-1:0]   load_data,
  input  logic [CNT_W-1:0]  load_bits,
  output logic              sclk,
  output logic              sdata,
  output logic              finish
);
  localparam int PH_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLK_DIV - 1);
  localparam logic [PH_W-1:0] PH_HIGH = PH_W'(CLK_DIV / 2);

  logic [SR_W-1:0]  shreg_q;
  logic [CNT_W-1:0] left_q;
  logic [PH_W-1:0]  ph_q;
  logic             active_q;
  logic             bit_end;

  assign bit_end = active_q && (ph_q == PH_LAST);
  assign finish  = bit_end && (left_q == CNT_W'(1));

  // reset state is a running zero flush of RESET_BITS bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q  <= '0;
      left_q   <= CNT_W'(RESET_BITS);
      ph_q     <= '0;
      active_q <= 1'b1;
    end else if (load) begin
      shreg_q  <= load_data;
      left_q   <= load_bits;
      ph_q     <= '0;
      active_q <= (load_bits != '0);
    end else if (bit_end) begin
      shreg_q  <= {shreg_q[SR_W-2:0], 1'b0};
      left_q   <= left_q - CNT_W'(1);
      ph_q     <= '0;
      if (left_q == CNT_W'(1)) active_q <= 1'b0;
    end else if (active_q) begin
      ph_q <= ph_q + PH_W'(1);
    end
  end

  assign sclk  = active_q && (ph_q >= PH_HIGH);
  assign sdata = active_q && shreg_q[SR_W-1];
endmodule

// File: rtl/gs_frame_serializer.sv
module gs_frame_serializer #(
  parameter int NUM_CHIPS = 1,
  parameter int CLK_DIV   = 2,
  localparam int NCH      = gsser_pkg::chan_count(NUM_CHIPS),
  localparam int IDX_W    = $clog2(NCH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [11:0]       wr_data,
  input  logic              frame_req,
  output logic              sclk,
  output logic              sdata,
  output logic              busy,
  output logic              ready,
  output logic              latch_req,
  output logic              done,
  output logic              dirty
);
  import gsser_pkg::*;

  localparam int FRAME_BITS = frame_bits(NUM_CHIPS);
  localparam int FLUSH_BITS = flush_bits(NUM_CHIPS);
  localparam int CNT_W      = $clog2(FLUSH_BITS + 1);

  seq_state_t state_q;
  logic [FRAME_BITS-1:0] levels;
  logic wr_ok;
  logic start_evt;
  logic finish_w;
  logic done_q;
  logic dirty_q;

  gsser_store #(.NCH(NCH), .IDX_W(IDX_W), .GS_W(GS_BITS)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .wr_ok(wr_ok), .levels(levels)
  );

  // highest channel sits at the MSB end, so shifting left sends it first
  gsser_shifter #(.SR_W(FRAME_BITS), .CNT_W(CNT_W), .CLK_DIV(CLK_DIV),
                  .RESET_BITS(FLUSH_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(start_evt), .load_data(levels),
    .load_bits(CNT_W'(FRAME_BITS)), .sclk(sclk), .sdata(sdata),
    .finish(finish_w)
  );

  assign start_evt = (state_q == ST_IDLE) && frame_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FLUSH;
      done_q  <= 1'b0;
      dirty_q <= 1'b0;
    end else begin
      done_q <= (state_q == ST_SEND) && finish_w;
      if (wr_ok)          dirty_q <= 1'b1;
      else if (start_evt) dirty_q <= 1'b0;
      unique case (state_q)
        ST_FLUSH: if (finish_w)  state_q <= ST_LATCH;
        ST_LATCH:                state_q <= ST_IDLE;
        ST_IDLE:  if (frame_req) state_q <= ST_SEND;
        ST_SEND:  if (finish_w)  state_q <= ST_IDLE;
        default:                 state_q <= ST_FLUSH;
      endcase
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign ready     = (state_q == ST_IDLE) || (state_q == ST_SEND);
  assign latch_req = (state_q == ST_LATCH);
  assign done      = done_q;
  assign dirty     = dirty_q;
endmodule

// File: rtl/gsser_checker.sv
module gsser_checker (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic sdata,
  input logic busy,
  input logic ready,
  input logic latch_req,
  input logic done,
  input logic dirty,
  input logic wr_en,
  input logic wr_ok,
  input logic start_evt
);
  a_r3_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);
  a_r3_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdata));
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !sclk));
  a_r9_dirty_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && !wr_ok) |=> !dirty);
  a_r5_write_marks: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> dirty);
  a_r4_bad_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_ok && !start_evt) |=> $stable(dirty));
  a_r6_latch_ready: assert property (@(posedge clk) disable iff (!rst_n)
    latch_req |=> (ready && !latch_req));
  a_r6_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
  a_r6_no_early_start: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !start_evt);
  a_r11_busy_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start_evt);
endmodule

bind gs_frame_serializer gsser_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata), .busy(busy),
  .ready(ready), .latch_req(latch_req), .done(done), .dirty(dirty),
  .wr_en(wr_en), .wr_ok(wr_ok), .start_evt(start_evt)
);

// File: tb/gs_frame_serializer_tb.sv
`timescale 1ns/1ps
module gs_frame_serializer_tb;
  localparam int CHIPS = 2;
  localparam int DIV   = 4;
  localparam int NCH   = CHIPS * 16;
  localparam int IDX_W = $clog2(NCH) + 1;
  localparam int FRAME = CHIPS * 192;
  localparam int FLUSH = CHIPS * 200;
  localparam int HIGHC = DIV - DIV / 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, frame_req = 1'b0;
  logic [IDX_W-1:0] wr_idx = '0;
  logic [11:0] wr_data = '0;
  logic sclk, sdata, busy, ready, latch_req, done, dirty;

  always #2 clk = ~clk;

  gs_frame_serializer #(.NUM_CHIPS(CHIPS), .CLK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .frame_req(frame_req), .sclk(sclk), .sdata(sdata),
    .busy(busy), .ready(ready), .latch_req(latch_req), .done(done),
    .dirty(dirty)
  );

  int checks = 0, errors = 0;
  logic [11:0] model [NCH];
  logic cap [$];
  int done_cnt = 0, latch_cnt = 0, bits_at_latch = -1;
  int period_bad = 0, high_bad = 0, hold_bad = 0;
  int since_rise = 0, hi_cnt = 0;
  bit in_burst = 0;
  logic prev_sclk = 0, prev_sdata = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: everything is sampled on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      since_rise++;
      if (sclk && !prev_sclk) begin
        cap.push_back(sdata);
        if (in_burst && since_rise != DIV) period_bad++;
        in_burst = 1;
        since_rise = 0;
      end
      if (sclk) hi_cnt++;
      if (!sclk && prev_sclk) begin
        if (hi_cnt != HIGHC) high_bad++;
        hi_cnt = 0;
      end
      if (sclk && prev_sclk && sdata != prev_sdata) hold_bad++;
      if (!busy && sclk) hold_bad++;
      if (done) begin done_cnt++; in_burst = 0; end
      if (latch_req) begin
        latch_cnt++; in_burst = 0;
        if (bits_at_latch < 0) bits_at_latch = cap.size();
      end
    end
    prev_sclk = sclk;
    prev_sdata = sdata;
  end

  task automatic write_ch(input int idx, input int val);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_data = 12'(val);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic start_frame();
    cap.delete();
    done_cnt = 0;
    @(negedge clk); frame_req = 1'b1;
    @(negedge clk); frame_req = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < FRAME * DIV + 50 && done_cnt == 0; i++) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  task automatic compare_frame(input string req);
    int bad = 0, first = -1, ch, bt;
    check(cap.size() == FRAME, "R1", {req, " frame bit count"}, cap.size(), FRAME);
    for (int k = 0; k < FRAME && k < cap.size(); k++) begin
      ch = NCH - 1 - k / 12;
      bt = 11 - k % 12;
      if (cap[k] !== model[ch][bt]) begin bad++; if (first < 0) first = k; end
    end
    check(bad == 0, req, "mismatched bits (first at index)", first, -1);
    check(done_cnt == 1, "R9", {req, " done pulses"}, done_cnt, 1);
  endtask

  task automatic t_reset();
    for (int i = 0; i < NCH; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    check(sclk == 0 && sdata == 0 && done == 0 && dirty == 0 && ready == 0,
          "R7", "outputs under reset", {sclk, sdata, done, dirty, ready}, 0);
  endtask

  task automatic t_flush();
    frame_req = 1'b1;             // held through the clear: must be ignored
    rst_n = 1'b1;
    for (int i = 0; i < FLUSH * DIV + 50 && latch_cnt == 0; i++) @(negedge clk);
    frame_req = 1'b0;
    check(bits_at_latch == FLUSH, "R6", "zero bits before latch", bits_at_latch, FLUSH);
    begin
      int ones = 0;
      foreach (cap[i]) if (cap[i] !== 1'b0) ones++;
      check(ones == 0, "R6", "non-zero flush bits", ones, 0);
    end
    repeat (6) @(negedge clk);
    check(latch_cnt == 1, "R6", "latch pulses", latch_cnt, 1);
    check(ready == 1 && busy == 0, "R6", "ready and idle after clear", {ready, busy}, 2);
    check(done_cnt == 0, "R6", "frame started during clear", done_cnt, 0);
  endtask

  task automatic t_zero_frame();
    start_frame();
    wait_done();
    compare_frame("R7");
    check(period_bad == 0, "R10", "bit periods not equal to CLK_DIV", period_bad, 0);
    check(high_bad == 0, "R10", "high phases of wrong length", high_bad, 0);
  endtask

  task automatic t_writes();
    int vals [5] = '{12'hA5C, 12'h001, 12'h800, 12'hFFF, 12'h3C7};
    int idxs [5] = '{0, 1, 17, NCH - 1, 9};
    foreach (idxs[i]) begin
      write_ch(idxs[i], vals[i]);
      model[idxs[i]] = 12'(vals[i]);
    end
    check(dirty == 1, "R5", "dirty after write", dirty, 1);
    write_ch(9, 12'h5A3);         // overwrite: only channel 9 changes
    model[9] = 12'h5A3;
    start_frame();
    check(dirty == 0, "R9", "dirty after frame start", dirty, 1'b0);
    wait_done();
    compare_frame("R2");
    check(busy == 0 && sclk == 0, "R3", "idle clock level", {busy, sclk}, 0);
  endtask

  task automatic t_bad_index();
    write_ch(NCH + 5, 12'hFFF);   // aliases channel 5 if the top index bit is lost
    write_ch((1 << IDX_W) - 1, 12'h777);
    check(dirty == 0, "R4", "dirty after out-of-range writes", dirty, 0);
    start_frame();
    wait_done();
    compare_frame("R4");
  endtask

  task automatic t_mid_write();
    start_frame();
    repeat (60 * DIV) @(negedge clk);   // channels NCH-1..NCH-5 already gone
    write_ch(NCH - 1, 12'h0F0);
    write_ch(0, 12'hE1E);
    @(negedge clk); frame_req = 1'b1;   // request while busy: ignored
    @(negedge clk); frame_req = 1'b0;
    wait_done();
    repeat (FRAME / 4) @(negedge clk);
    compare_frame("R8");
    check(busy == 0, "R11", "busy after ignored request", busy, 0);
    check(dirty == 1, "R8", "dirty after write during frame", dirty, 1);
    model[NCH - 1] = 12'h0F0;
    model[0] = 12'hE1E;
    start_frame();
    wait_done();
    compare_frame("R8");
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_flush();
    t_zero_frame();
    t_writes();
    t_bad_index();
    t_mid_write();
    check(hold_bad == 0, "R3", "data changes while clock high", hold_bad, 0);
    check(period_bad == 0 && high_bad == 0, "R10", "clock shape errors",
          period_bad + high_bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule